// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Controller

This block is the digital measure-and-correct engine of a frequency-locked loop. A reference clock and the output of a trimmable oscillator both come in as raw levels. Each passes through a small synchronizer and a rising-edge detector, so everything runs on one fast sampling clock. A measurement window spans a programmable number of reference periods. The oscillator edges counted in that window are compared with a programmed target count, and the signed difference drives a proportional-integral filter. The filter moves a 9-bit trim word, which the oscillator uses to set its frequency.

The filter gains are power-of-two shifts. A narrow dead band leaves the trim alone when the error is already small. A wider tolerance decides the lock indication. After every trim change the next window waits a programmable number of reference periods, so the oscillator can settle first. The loop's swing around the initial trim is capped by a programmable limit. An open-loop setting freezes the trim at its initial value while lock is still judged. A range code for the oscillator passes straight through. Software pulses a load input after writing a new configuration, and that pulse restarts the loop.

Top module: `fll_loop_top`

## Requirements
- R1: Oscillator rising edges are counted over a window of `refDiv` reference periods, with `refDiv` = 0 treated as 1. The window opens on a reference rising edge and closes on the reference rising edge `refDiv` periods later. The error is `multTarget` minus the count, as a signed value. The count saturates at 2^19-1.
- R2: When an update changes the trim, the next window opens on reference edge number `settleCount`+1 after the update. When the trim is unchanged, the next window opens on the first reference edge after the update.
- R3: At each update, `locked` becomes 1 if |error| <= `lockTol` and 0 otherwise. It changes at no other time, apart from R8.
- R4: When |error| <= `updTol`, the update leaves both the trim and the integral state unchanged.
- R5: Outside the dead band, the integral state (8 fractional bits) gains error·2^iGain and is clamped to ±`trimLimit`·256. The offset is floor((integral + error·2^pGain)/256), clamped to ±`trimLimit`. Gain codes above 11 act as 11, so each effective gain is 2^(g-8).
- R6: `trimOut` = `initTrim` + offset, saturated to 0..511. It changes only together with `updStrobe`, on a clear, or when `initTrim` changes.
- R7: With `openLoop` = 1, `trimOut` stays at `initTrim`, while `locked` is still evaluated.
- R8: Reset, a `cfgLoad` pulse or `enable` = 0 clears the offset, the integral state, the window counters and `locked`. On the next cycle `trimOut` equals `initTrim`.
- R9: `updStrobe` is high for exactly one cycle per completed window. That is the first cycle in which the new `trimOut` and `locked` are visible.
- R10: `rangeOut` always equals `rangeSel`.
- R11: An oscillator edge that arrives in the same cycle as the window-opening reference edge is not counted. One that arrives in the same cycle as the window-closing reference edge is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Loop run enable; low clears the loop |
| cfgLoad | input | 1 | One-cycle pulse after the configuration changes; clears the loop |
| refIn | input | 1 | Raw reference clock level |
| oscIn | input | 1 | Raw oscillator clock level |
| multTarget | input | 18 | Ideal oscillator count per window |
| refDiv | input | 13 | Reference periods per window |
| pGain | input | 4 | Proportional gain code |
| iGain | input | 4 | Integral gain code |
| lockTol | input | 9 | Lock tolerance in counts |
| updTol | input | 9 | Dead-band tolerance in counts |
| settleCount | input | 16 | Reference periods to wait after a trim change |
| openLoop | input | 1 | Freeze trim at initTrim |
| initTrim | input | 9 | Starting trim |
| rangeSel | input | 3 | Oscillator range code |
| trimLimit | input | 8 | Maximum offset magnitude |
| trimOut | output | 9 | Applied oscillator trim |
| rangeOut | output | 3 | Range code passthrough |
| locked | output | 1 | Lock indication |
| updStrobe | output | 1 | One-cycle pulse marking a completed update |

## Verification
The bench closes the loop through a phase-accumulator oscillator whose rate follows `trimOut`. It drives the reference and the oscillator so that their edges sometimes land in the same cycle, which exposes a window boundary that is off by one: the strobe moves by a reference period, or the count differs by one. Gain codes of 15 and a small `trimLimit` push the filter into integral and offset clamping, with `initTrim` at both ends of the range. A design missing saturation there would wrap the trim from 511 to a low value, or from 0 to a high one. A dead band wider than any error, open-loop mode, `refDiv` = 0 and a load pulse in the middle of a run check that nothing drifts when it must hold. They also check that a disabled loop does not keep stale lock state or a stale offset.

// File: rtl/fll_pkg.sv
`timescale 1ns/1ps
package fll_pkg;
  localparam int MULT_W   = 18;
  localparam int DIV_W    = 13;
  localparam int TRIM_W   = 9;
  localparam int TOL_W    = 9;
  localparam int GAIN_W   = 4;
  localparam int SETTLE_W = 16;
  localparam int LIMIT_W  = 8;
  localparam int RANGE_W  = 3;
  localparam int FRAC_W   = 8;
  localparam int MAX_GAIN = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_MEASURE, ST_UPDATE} loopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic winStart;
    logic measuring;
    logic doUpdate;
  } loopStrobe_t;
endpackage

// File: rtl/fll_edge_sampler.sv
`timescale 1ns/1ps
module fll_edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawIn,
  output logic risePulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic lastQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[s] <= 1'b0;
        else if (s == 0) syncQ[s] <= rawIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lastQ <= 1'b0;
    else lastQ <= syncQ[SYNC_STAGES-1];
  end

  assign risePulse = syncQ[SYNC_STAGES-1] & ~lastQ;
endmodule

// File: rtl/fll_loop_ctrl.sv
`timescale 1ns/1ps
module fll_loop_ctrl
  import fll_pkg::*;
#(
  parameter int DIV_W    = 13,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cfgLoad,
  input  logic                refTick,
  input  logic [DIV_W-1:0]    refDiv,
  input  logic [SETTLE_W-1:0] settleCount,
  input  logic                trimChanged,
  output loopStrobe_t         strobe,
  output logic                updStrobe
);
  loopState_t state;
  logic [SETTLE_W-1:0] settleCnt, settleTarget;
  logic [DIV_W-1:0]    divCnt, lastDiv;
  logic skipSettle, clearReq, settleDone;

  always_comb begin
    clearReq     = cfgLoad | ~enable;
    settleTarget = skipSettle ? '0 : settleCount;
    settleDone   = settleCnt >= settleTarget;
    lastDiv      = (refDiv == '0) ? '0 : refDiv - DIV_W'(1);
    strobe.clear     = clearReq;
    strobe.winStart  = !clearReq && (state == ST_SETTLE) && refTick && settleDone;
    strobe.measuring = !clearReq && (state == ST_MEASURE);
    strobe.doUpdate  = !clearReq && (state == ST_UPDATE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      settleCnt  <= '0;
      divCnt     <= '0;
      skipSettle <= 1'b0;
      updStrobe  <= 1'b0;
    end else begin
      updStrobe <= !clearReq && (state == ST_UPDATE);
      if (clearReq) begin
        state      <= ST_IDLE;
        settleCnt  <= '0;
        divCnt     <= '0;
        skipSettle <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state      <= ST_SETTLE;
            settleCnt  <= '0;
            skipSettle <= 1'b0;
          end
          ST_SETTLE: begin
            if (refTick) begin
              if (settleDone) begin
                state  <= ST_MEASURE;
                divCnt <= '0;
              end else begin
                settleCnt <= settleCnt + SETTLE_W'(1);
              end
            end
          end
          ST_MEASURE: begin
            if (refTick) begin
              if (divCnt == lastDiv) state <= ST_UPDATE;
              else divCnt <= divCnt + DIV_W'(1);
            end
          end
          default: begin
            state      <= ST_SETTLE;
            settleCnt  <= '0;
            skipSettle <= !trimChanged;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fll_loop_datapath.sv
`timescale 1ns/1ps
module fll_loop_datapath
  import fll_pkg::*;
#(
  parameter int MULT_W   = 18,
  parameter int TRIM_W   = 9,
  parameter int TOL_W    = 9,
  parameter int GAIN_W   = 4,
  parameter int LIMIT_W  = 8,
  parameter int FRAC_W   = 8,
  parameter int MAX_G    = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  loopStrobe_t        strobe,
  input  logic               oscTick,
  input  logic [MULT_W-1:0]  multTarget,
  input  logic [TRIM_W-1:0]  initTrim,
  input  logic [TOL_W-1:0]   lockTol,
  input  logic [TOL_W-1:0]   updTol,
  input  logic [GAIN_W-1:0]  pGain,
  input  logic [GAIN_W-1:0]  iGain,
  input  logic [LIMIT_W-1:0] trimLimit,
  input  logic               openLoop,
  output logic [TRIM_W-1:0]  trimOut,
  output logic               locked,
  output logic               trimChanged
);
  localparam int CNT_W  = MULT_W + 1;
  localparam int ERR_W  = CNT_W + 1;
  localparam int ACC_W  = LIMIT_W + FRAC_W + 1;
  localparam int OFF_W  = LIMIT_W + 1;
  localparam int WIDE_W = ERR_W + MAX_G + 2;
  localparam logic signed [WIDE_W-1:0] TRIM_TOP = WIDE_W'((1 << TRIM_W) - 1);

  logic [CNT_W-1:0]         oscCount;
  logic signed [ACC_W-1:0]  acc;
  logic signed [OFF_W-1:0]  offset;
  logic signed [ERR_W-1:0]  err;
  logic [ERR_W-1:0]         absErr;
  logic [GAIN_W-1:0]        pSh, iSh;
  logic signed [WIDE_W-1:0] errW, accW, offW, initW, limW, accLim;
  logic signed [WIDE_W-1:0] accSum, accNext, piSum, offRaw, offNext;
  logic [TRIM_W-1:0]        newTrim;
  logic                     applyUpd;

  function automatic logic [TRIM_W-1:0] satTrim(input logic signed [WIDE_W-1:0] v);
    if (v < 0) return '0;
    else if (v > TRIM_TOP) return '1;
    else return v[TRIM_W-1:0];
  endfunction

  always_comb begin
    err    = $signed(ERR_W'(multTarget) - ERR_W'(oscCount));
    absErr = err[ERR_W-1] ? -err : err;
    pSh    = (pGain > GAIN_W'(MAX_G)) ? GAIN_W'(MAX_G) : pGain;
    iSh    = (iGain > GAIN_W'(MAX_G)) ? GAIN_W'(MAX_G) : iGain;
    errW   = {{(WIDE_W-ERR_W){err[ERR_W-1]}}, err};
    accW   = {{(WIDE_W-ACC_W){acc[ACC_W-1]}}, acc};
    offW   = {{(WIDE_W-OFF_W){offset[OFF_W-1]}}, offset};
    initW  = {{(WIDE_W-TRIM_W){1'b0}}, initTrim};
    limW   = {{(WIDE_W-LIMIT_W){1'b0}}, trimLimit};
    accLim = limW <<< FRAC_W;
    // integral path with anti-windup clamp
    accSum = accW + (errW <<< iSh);
    if (accSum > accLim) accNext = accLim;
    else if (accSum < -accLim) accNext = -accLim;
    else accNext = accSum;
    // proportional term added, fraction dropped by floor
    piSum  = accNext + (errW <<< pSh);
    offRaw = piSum >>> FRAC_W;
    if (offRaw > limW) offNext = limW;
    else if (offRaw < -limW) offNext = -limW;
    else offNext = offRaw;
    applyUpd    = !openLoop && (absErr > ERR_W'(updTol));
    trimOut     = satTrim(initW + offW);
    newTrim     = satTrim(initW + offNext);
    trimChanged = applyUpd && (newTrim != trimOut);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oscCount <= '0;
      acc      <= '0;
      offset   <= '0;
      locked   <= 1'b0;
    end else if (strobe.clear) begin
      oscCount <= '0;
      acc      <= '0;
      offset   <= '0;
      locked   <= 1'b0;
    end else begin
      if (strobe.winStart) oscCount <= '0;
      else if (strobe.measuring && oscTick && (oscCount != '1)) oscCount <= oscCount + CNT_W'(1);
      if (strobe.doUpdate) begin
        locked <= absErr <= ERR_W'(lockTol);
        if (applyUpd) begin
          acc    <= accNext[ACC_W-1:0];
          offset <= offNext[OFF_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/fll_loop_top.sv
`timescale 1ns/1ps
module fll_loop_top
  import fll_pkg::*;
#(
  parameter int MULT_W      = fll_pkg::MULT_W,
  parameter int DIV_W       = fll_pkg::DIV_W,
  parameter int TRIM_W      = fll_pkg::TRIM_W,
  parameter int TOL_W       = fll_pkg::TOL_W,
  parameter int GAIN_W      = fll_pkg::GAIN_W,
  parameter int SETTLE_W    = fll_pkg::SETTLE_W,
  parameter int LIMIT_W     = fll_pkg::LIMIT_W,
  parameter int RANGE_W     = fll_pkg::RANGE_W,
  parameter int FRAC_W      = fll_pkg::FRAC_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cfgLoad,
  input  logic                refIn,
  input  logic                oscIn,
  input  logic [MULT_W-1:0]   multTarget,
  input  logic [DIV_W-1:0]    refDiv,
  input  logic [GAIN_W-1:0]   pGain,
  input  logic [GAIN_W-1:0]   iGain,
  input  logic [TOL_W-1:0]    lockTol,
  input  logic [TOL_W-1:0]    updTol,
  input  logic [SETTLE_W-1:0] settleCount,
  input  logic                openLoop,
  input  logic [TRIM_W-1:0]   initTrim,
  input  logic [RANGE_W-1:0]  rangeSel,
  input  logic [LIMIT_W-1:0]  trimLimit,
  output logic [TRIM_W-1:0]   trimOut,
  output logic [RANGE_W-1:0]  rangeOut,
  output logic                locked,
  output logic                updStrobe
);
  logic refTick, oscTick, trimChanged;
  loopStrobe_t strobe;

  fll_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_refSampler (
    .clk(clk), .rst_n(rst_n), .rawIn(refIn), .risePulse(refTick));

  fll_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_oscSampler (
    .clk(clk), .rst_n(rst_n), .rawIn(oscIn), .risePulse(oscTick));

  fll_loop_ctrl #(.DIV_W(DIV_W), .SETTLE_W(SETTLE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgLoad(cfgLoad),
    .refTick(refTick), .refDiv(refDiv), .settleCount(settleCount),
    .trimChanged(trimChanged), .strobe(strobe), .updStrobe(updStrobe));

  fll_loop_datapath #(
    .MULT_W(MULT_W), .TRIM_W(TRIM_W), .TOL_W(TOL_W), .GAIN_W(GAIN_W),
    .LIMIT_W(LIMIT_W), .FRAC_W(FRAC_W), .MAX_G(MAX_GAIN)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .oscTick(oscTick),
    .multTarget(multTarget), .initTrim(initTrim), .lockTol(lockTol),
    .updTol(updTol), .pGain(pGain), .iGain(iGain), .trimLimit(trimLimit),
    .openLoop(openLoop), .trimOut(trimOut), .locked(locked),
    .trimChanged(trimChanged));

  assign rangeOut = rangeSel;
endmodule

// File: rtl/fll_loop_checker.sv
`timescale 1ns/1ps
module fll_loop_checker #(
  parameter int TRIM_W  = 9,
  parameter int LIMIT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               cfgLoad,
  input logic               openLoop,
  input logic [TRIM_W-1:0]  initTrim,
  input logic [LIMIT_W-1:0] trimLimit,
  input logic [TRIM_W-1:0]  trimOut,
  input logic               locked,
  input logic               updStrobe
);
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    updStrobe |=> !updStrobe);

  assert_clear_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLoad || !enable) |=> !locked);

  assert_clear_trim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLoad || !enable) |=> (trimOut == initTrim));

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(cfgLoad) && !updStrobe) |-> $stable(locked));

  assert_trim_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(cfgLoad) && !updStrobe && $stable(initTrim)) |-> $stable(trimOut));

  assert_open_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (openLoop && updStrobe) |-> (trimOut == initTrim));

  assert_offset_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgLoad |-> ((int'(trimOut) <= int'(initTrim) + int'(trimLimit)) &&
                  (int'(trimOut) + int'(trimLimit) >= int'(initTrim))));
endmodule

bind fll_loop_top fll_loop_checker #(.TRIM_W(TRIM_W), .LIMIT_W(LIMIT_W)) u_check (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cfgLoad(cfgLoad),
  .openLoop(openLoop), .initTrim(initTrim), .trimLimit(trimLimit),
  .trimOut(trimOut), .locked(locked), .updStrobe(updStrobe));

// File: tb/fll_loop_top_bench.sv
`timescale 1ns/1ps
module fll_loop_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cfgLoad = 1'b0;
  logic refIn = 1'b0, oscIn = 1'b0, openLoop = 1'b0;
  logic [17:0] multTarget = '0;
  logic [12:0] refDiv = '0;
  logic [3:0]  pGain = '0, iGain = '0;
  logic [8:0]  lockTol = '0, updTol = '0, initTrim = '0;
  logic [15:0] settleCount = '0;
  logic [2:0]  rangeSel = '0;
  logic [7:0]  trimLimit = '0;
  logic [8:0]  trimOut;
  logic [2:0]  rangeOut;
  logic        locked, updStrobe;

  int checks = 0, fails = 0, strobeSeen = 0;
  bit finished = 0;

  // reference model state
  int mS0r, mS1r, mPr, mS0o, mS1o, mPo;
  int mState, mSettle, mDiv, mCount, mSkip, mLock, mStrobe;
  longint mAcc, mOff;
  int refPh = 0;
  int oscPh = 0;

  fll_loop_top u_fll_loop_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgLoad(cfgLoad),
    .refIn(refIn), .oscIn(oscIn), .multTarget(multTarget), .refDiv(refDiv),
    .pGain(pGain), .iGain(iGain), .lockTol(lockTol), .updTol(updTol),
    .settleCount(settleCount), .openLoop(openLoop), .initTrim(initTrim),
    .rangeSel(rangeSel), .trimLimit(trimLimit), .trimOut(trimOut),
    .rangeOut(rangeOut), .locked(locked), .updStrobe(updStrobe));

  always #2.5 clk = ~clk;

  function automatic int satT(longint v);
    if (v < 0) return 0;
    if (v > 511) return 511;
    return int'(v);
  endfunction

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    int tr, to, ig, pg, ae, prevT, lastD, tgt;
    longint err, a, s, o, lim;
    tr = (mS1r != 0 && mPr == 0) ? 1 : 0;
    to = (mS1o != 0 && mPo == 0) ? 1 : 0;
    mPr = mS1r; mS1r = mS0r; mS0r = int'(refIn);
    mPo = mS1o; mS1o = mS0o; mS0o = int'(oscIn);
    if (!rst_n) begin
      mS0r = 0; mS1r = 0; mPr = 0; mS0o = 0; mS1o = 0; mPo = 0;
      mState = 0; mSettle = 0; mDiv = 0; mCount = 0; mSkip = 0;
      mLock = 0; mStrobe = 0; mAcc = 0; mOff = 0;
    end else begin
      mStrobe = (enable && !cfgLoad && mState == 3) ? 1 : 0;
      if (cfgLoad || !enable) begin
        mState = 0; mSettle = 0; mDiv = 0; mCount = 0; mSkip = 0;
        mLock = 0; mAcc = 0; mOff = 0;
      end else begin
        case (mState)
          0: begin mState = 1; mSettle = 0; mSkip = 0; end
          1: if (tr) begin
               tgt = mSkip ? 0 : int'(settleCount);
               if (mSettle >= tgt) begin mState = 2; mDiv = 0; mCount = 0; end
               else mSettle++;
             end
          2: begin
               if (to && mCount < 524287) mCount++;
               if (tr) begin
                 lastD = (refDiv == 0) ? 0 : int'(refDiv) - 1;
                 if (mDiv == lastD) mState = 3; else mDiv++;
               end
             end
          default: begin
            err = longint'(multTarget) - longint'(mCount);
            ae = int'(err < 0 ? -err : err);
            mLock = (ae <= int'(lockTol)) ? 1 : 0;
            prevT = satT(longint'(initTrim) + mOff);
            if (!openLoop && ae > int'(updTol)) begin
              ig = (iGain > 11) ? 11 : int'(iGain);
              pg = (pGain > 11) ? 11 : int'(pGain);
              lim = longint'(trimLimit);
              a = mAcc + err * (longint'(1) << ig);
              if (a > lim * 256) a = lim * 256;
              if (a < -lim * 256) a = -lim * 256;
              mAcc = a;
              s = a + err * (longint'(1) << pg);
              o = s >>> 8;
              if (o > lim) o = lim;
              if (o < -lim) o = -lim;
              mOff = o;
            end
            mState = 1; mSettle = 0;
            mSkip = (satT(longint'(initTrim) + mOff) == prevT) ? 1 : 0;
          end
        endcase
      end
    end
  end

  // compare on each falling edge, then move the raw clocks
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        checkEq("R5 R6 trim", int'(trimOut), satT(longint'(initTrim) + mOff));
        checkEq("R3 locked", int'(locked), mLock);
        checkEq("R1 R2 R9 R11 strobe", int'(updStrobe), mStrobe);
        checkEq("R10 range", int'(rangeOut), int'(rangeSel));
        if (updStrobe) strobeSeen++;
      end
      refPh = (refPh + 1) % 80;
      refIn = (refPh < 40);
      oscPh = (oscPh + 2000 + 8 * int'(trimOut)) % 65536;
      oscIn = (oscPh >= 32768);
    end
  end

  task automatic loadCfg(int mt, int rd, int pg, int ig, int lt, int ut, int sc,
                         bit ol, int it, int rs, int lm);
    @(negedge clk); #1;
    multTarget = 18'(mt); refDiv = 13'(rd); pGain = 4'(pg); iGain = 4'(ig);
    lockTol = 9'(lt); updTol = 9'(ut); settleCount = 16'(sc); openLoop = ol;
    initTrim = 9'(it); rangeSel = 3'(rs); trimLimit = 8'(lm);
    cfgLoad = 1'b1; enable = 1'b1;
    @(negedge clk); #1;
    cfgLoad = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R9 actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state (R8)
    checkEq("R8 reset trim", int'(trimOut), 0);
    checkEq("R8 reset locked", int'(locked), 0);
    checkEq("R9 reset strobe", int'(updStrobe), 0);
    #1 rst_n = 1'b1;

    // closed loop toward target (R1 R2 R3 R5)
    loadCfg(40, 8, 8, 8, 2, 0, 3, 0, 200, 2, 255);
    strobeSeen = 0;
    repeat (25000) @(negedge clk);
    checks++;
    if (strobeSeen == 0) begin fails++; $display("FAIL R1 strobes actual 0 expected >0"); end
    checks++;
    if (trimOut == 9'd200) begin fails++; $display("FAIL R5 trim actual 200 expected moved"); end

    // open loop (R7)
    loadCfg(40, 8, 8, 8, 2, 0, 3, 1, 150, 1, 255);
    repeat (8000) @(negedge clk);
    checkEq("R7 open loop trim", int'(trimOut), 150);

    // dead band wider than any error (R4)
    loadCfg(40, 8, 8, 8, 2, 511, 3, 0, 200, 4, 255);
    repeat (8000) @(negedge clk);
    checkEq("R4 dead band trim", int'(trimOut), 200);

    // upper saturation with clamped, capped gains (R5 R6)
    loadCfg(100, 4, 15, 15, 3, 0, 2, 0, 510, 3, 4);
    repeat (6000) @(negedge clk);
    checkEq("R6 upper saturation", int'(trimOut), 511);

    // lower saturation (R6)
    loadCfg(5, 4, 15, 11, 3, 0, 2, 0, 3, 0, 4);
    repeat (6000) @(negedge clk);
    checkEq("R6 lower saturation", int'(trimOut), 0);

    // load pulse mid-run clears loop (R8)
    loadCfg(5, 4, 15, 11, 3, 0, 2, 0, 100, 0, 4);
    checkEq("R8 load trim", int'(trimOut), 100);
    checkEq("R8 load locked", int'(locked), 0);
    repeat (3000) @(negedge clk);
    #1 enable = 1'b0;
    @(negedge clk);
    checkEq("R8 disable trim", int'(trimOut), 100);
    checkEq("R8 disable locked", int'(locked), 0);

    // refDiv of zero acts as one, no settle pause (R1 R2 R11)
    loadCfg(4, 0, 6, 4, 1, 0, 0, 0, 256, 5, 255);
    strobeSeen = 0;
    repeat (4000) @(negedge clk);
    checks++;
    if (strobeSeen == 0) begin fails++; $display("FAIL R1 short window strobes actual 0 expected >0"); end

    finished = 1;
    summary();
    $finish;
  end
endmodule